// File: doc/BRIEF.md
# Two-Wire Camera Control Bridge

This block lets a host program a camera sensor over a two-wire serial control bus (SCCB, an I2C-like protocol) through a small byte-wide register window. The host stores a target register index and, for writes, a data byte. A single opcode write then runs the whole bus transaction. The host polls a status byte until it shows a result, and after a read it collects the fetched byte from its own offset.

A write puts the device address, the index and the value on the bus in three acknowledged phases. A read sends the address and the index, issues a STOP, then issues a fresh START with the read address. It receives one byte and answers it with NACK. A bus-enable register must hold a value above 0x01 before any transaction can launch. Both bus lines are open-drain: the block only ever pulls a line low through an output-enable. SCL is produced from the system clock by a quarter-period divider.

Top module: `sccb_bridge`

## Requirements
- R1: After reset, status (offset 1) reads 0x00, enable (offset 2) reads 0x00, address (offset 3) reads 0x60, read data (offset 9) reads 0x00, and neither line is pulled low.
- R2: Writing 0x05 to offset 0 produces START, address byte, write-index byte (offset 4), write-value byte (offset 5), STOP, each byte acknowledged. Status then becomes 0x04.
- R3: Writing 0x70 to offset 0 produces START, write-address byte, read-index byte (offset 8), STOP, START, address byte with bit 0 set, eight received bits with a NACK, and STOP. Status then becomes 0x01 and offset 9 holds the received byte.
- R4: Status reads 0x00 for the whole time a transaction is in progress. Launching a transaction clears it.
- R5: While the enable register holds 0x00 or 0x01, an opcode write starts nothing: no line is pulled and status keeps its value. Values above 0x01 (for example 0x1E) allow transactions.
- R6: A missing acknowledge on any transmitted byte ends the transaction with a STOP and sets status 0x80. Offset 9 is left unchanged.
- R7: SDA changes only while SCL is low, except for the START and STOP edges.
- R8: An opcode written while a transaction is in progress is ignored, and so is any opcode value other than 0x05 or 0x70.
- R9: Bits 7:1 of the address register (offset 3) form the 7-bit device address. The bus byte carries them with bit 0 replaced by the direction (0 write, 1 read).
- R10: Each data bit occupies four quarter periods of QDIV system clocks each, so consecutive SCL rising edges within a byte are 4*QDIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per register write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on bus_addr (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1; released (pulled up) when 0 |
| sda_oe | output | 1 | Pull SDA low when 1; released (pulled up) when 0 |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
The assertions assume the host issues at most one register write per cycle, and that the SDA level seen on sda_in follows the block's own pull whenever a device is not answering. They also assume no other master drives SCL, because the block neither senses SCL nor waits on it. The bench keeps within this. It models a single responding device that pulls SDA only in acknowledge slots and in the bits it returns, and releases it everywhere else. It issues bus writes one at a time on falling clock edges.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  localparam int AW = 4;
  localparam int DW = 8;

  localparam logic [AW-1:0] OFS_OP   = 4'd0;
  localparam logic [AW-1:0] OFS_STAT = 4'd1;
  localparam logic [AW-1:0] OFS_EN   = 4'd2;
  localparam logic [AW-1:0] OFS_ADDR = 4'd3;
  localparam logic [AW-1:0] OFS_WIDX = 4'd4;
  localparam logic [AW-1:0] OFS_WVAL = 4'd5;
  localparam logic [AW-1:0] OFS_RIDX = 4'd8;
  localparam logic [AW-1:0] OFS_RDAT = 4'd9;

  localparam logic [DW-1:0] OPC_WRITE = 8'h05;
  localparam logic [DW-1:0] OPC_READ  = 8'h70;

  localparam logic [DW-1:0] ST_BUSY = 8'h00;
  localparam logic [DW-1:0] ST_WOK  = 8'h04;
  localparam logic [DW-1:0] ST_ROK  = 8'h01;
  localparam logic [DW-1:0] ST_ERR  = 8'h80;

  localparam logic [DW-1:0] ADDR_RST = 8'h60;
  localparam logic [DW-1:0] EN_MAX_OFF = 8'h01;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_START,
    SQ_BYTE,
    SQ_STOP
  } seq_st_e;
endpackage

// File: rtl/sccb_qtick.sv
module sccb_qtick #(
  parameter int QDIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == LAST);
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sccb_seq.sv
module sccb_seq
  import sccb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic          go_rd,
  input  logic [6:0]    slv_addr,
  input  logic [DW-1:0] w_idx,
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] r_idx,
  input  logic          sda_in,
  output logic          scl_lvl,
  output logic          sda_lvl,
  output logic          busy,
  output logic          done,
  output logic          nack,
  output logic [DW-1:0] rx_byte
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  seq_st_e       st_q, st_d;
  logic [1:0]    ph_q, ph_d;
  logic [3:0]    bit_q, bit_d;
  logic [1:0]    seg_q, seg_d;
  logic          rd_q, rd_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          ack_q, ack_d;
  logic          nack_q, nack_d;
  logic          done_q, done_d;
  logic [6:0]    a_q, a_d;
  logic [DW-1:0] idx_q, idx_d;
  logic [DW-1:0] val_q, val_d;
  logic          rx_seg;
  logic          last_seg;

  function automatic logic [DW-1:0] seg_byte(input logic [1:0] s, input logic rd,
                                             input logic [6:0] a, input logic [DW-1:0] ix,
                                             input logic [DW-1:0] v);
    case (s)
      2'd0:    seg_byte = {a, 1'b0};
      2'd1:    seg_byte = ix;
      default: seg_byte = rd ? {a, 1'b1} : v;
    endcase
  endfunction

  assign rx_seg   = rd_q && (seg_q == 2'd3);
  assign last_seg = rd_q ? (seg_q == 2'd1 || seg_q == 2'd3) : (seg_q == 2'd2);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    seg_d  = seg_q;
    rd_d   = rd_q;
    sh_d   = sh_q;
    ack_d  = ack_q;
    nack_d = nack_q;
    a_d    = a_q;
    idx_d  = idx_q;
    val_d  = val_q;
    done_d = 1'b0;
    if (st_q == SQ_IDLE) begin
      if (go) begin
        st_d   = SQ_START;
        ph_d   = 2'd0;
        seg_d  = 2'd0;
        rd_d   = go_rd;
        nack_d = 1'b0;
        a_d    = slv_addr;
        idx_d  = go_rd ? r_idx : w_idx;
        val_d  = w_val;
      end
    end else if (tick) begin
      ph_d = ph_q + 2'd1;
      case (st_q)
        SQ_START: begin
          if (ph_q == 2'd3) begin
            st_d  = SQ_BYTE;
            bit_d = 4'd0;
            sh_d  = seg_byte(seg_q, rd_q, a_q, idx_q, val_q);
          end
        end
        SQ_BYTE: begin
          if (ph_q == 2'd2) begin
            if (bit_q == ACK_BIT) ack_d = sda_in;
            else if (rx_seg)      sh_d  = {sh_q[DW-2:0], sda_in};
          end
          if (ph_q == 2'd3) begin
            if (bit_q != ACK_BIT) begin
              bit_d = bit_q + 4'd1;
              if (!rx_seg) sh_d = {sh_q[DW-2:0], 1'b0};
            end else begin
              bit_d = 4'd0;
              if (!rx_seg && ack_q) begin
                nack_d = 1'b1;
                st_d   = SQ_STOP;
              end else if (last_seg) begin
                st_d = SQ_STOP;
              end else begin
                seg_d = seg_q + 2'd1;
                sh_d  = seg_byte(seg_q + 2'd1, rd_q, a_q, idx_q, val_q);
              end
            end
          end
        end
        SQ_STOP: begin
          if (ph_q == 2'd3) begin
            if (!nack_q && rd_q && seg_q == 2'd1) begin
              st_d  = SQ_START;
              seg_d = 2'd2;
            end else begin
              st_d   = SQ_IDLE;
              done_d = 1'b1;
            end
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      SQ_START: begin
        scl_lvl = (ph_q != 2'd3);
        sda_lvl = (ph_q < 2'd2);
      end
      SQ_BYTE: begin
        scl_lvl = (ph_q == 2'd1) || (ph_q == 2'd2);
        sda_lvl = (bit_q == ACK_BIT) || rx_seg || sh_q[DW-1];
      end
      SQ_STOP: begin
        scl_lvl = (ph_q != 2'd0);
        sda_lvl = (ph_q >= 2'd2);
      end
      default: begin
        scl_lvl = 1'b1;
        sda_lvl = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ph_q   <= 2'd0;
      bit_q  <= 4'd0;
      seg_q  <= 2'd0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
      done_q <= 1'b0;
      a_q    <= '0;
      idx_q  <= '0;
      val_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      seg_q  <= seg_d;
      rd_q   <= rd_d;
      sh_q   <= sh_d;
      ack_q  <= ack_d;
      nack_q <= nack_d;
      done_q <= done_d;
      a_q    <= a_d;
      idx_q  <= idx_d;
      val_q  <= val_d;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign done    = done_q;
  assign nack    = nack_q;
  assign rx_byte = sh_q;

  // R7
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_lvl) && scl_lvl && (sda_lvl != $past(sda_lvl)))
      |-> (st_q == SQ_START || st_q == SQ_STOP));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == SQ_IDLE && scl_lvl && sda_lvl));
endmodule

// File: rtl/sccb_regs.sv
module sccb_regs
  import sccb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_busy,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [DW-1:0] eng_rx,
  output logic          go,
  output logic          go_rd,
  output logic [6:0]    slv_addr,
  output logic [DW-1:0] w_idx,
  output logic [DW-1:0] w_val,
  output logic [DW-1:0] r_idx
);
  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] en_q, en_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] widx_q, widx_d;
  logic [DW-1:0] wval_q, wval_d;
  logic [DW-1:0] ridx_q, ridx_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          kind_q, kind_d;
  logic          op_hit, op_known, gate_ok;

  always_comb begin
    op_hit   = bus_wr && (bus_addr == OFS_OP);
    op_known = (bus_wdata == OPC_WRITE) || (bus_wdata == OPC_READ);
    gate_ok  = (en_q > EN_MAX_OFF);
    go       = op_hit && op_known && gate_ok && !eng_busy;
    go_rd    = (bus_wdata == OPC_READ);
  end

  always_comb begin
    en_d   = en_q;
    addr_d = addr_q;
    widx_d = widx_q;
    wval_d = wval_q;
    ridx_d = ridx_q;
    if (bus_wr) begin
      case (bus_addr)
        OFS_EN:   en_d   = bus_wdata;
        OFS_ADDR: addr_d = bus_wdata;
        OFS_WIDX: widx_d = bus_wdata;
        OFS_WVAL: wval_d = bus_wdata;
        OFS_RIDX: ridx_d = bus_wdata;
        default:  ;
      endcase
    end
    kind_d = go ? go_rd : kind_q;
    stat_d = stat_q;
    if (go)            stat_d = ST_BUSY;
    else if (eng_done) stat_d = eng_nack ? ST_ERR : (kind_q ? ST_ROK : ST_WOK);
    rdat_d = (eng_done && kind_q && !eng_nack) ? eng_rx : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_BUSY;
      en_q   <= '0;
      addr_q <= ADDR_RST;
      widx_q <= '0;
      wval_q <= '0;
      ridx_q <= '0;
      rdat_q <= '0;
      kind_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      addr_q <= addr_d;
      widx_q <= widx_d;
      wval_q <= wval_d;
      ridx_q <= ridx_d;
      rdat_q <= rdat_d;
      kind_q <= kind_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_STAT: bus_rdata = stat_q;
      OFS_EN:   bus_rdata = en_q;
      OFS_ADDR: bus_rdata = addr_q;
      OFS_WIDX: bus_rdata = widx_q;
      OFS_WVAL: bus_rdata = wval_q;
      OFS_RIDX: bus_rdata = ridx_q;
      OFS_RDAT: bus_rdata = rdat_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign slv_addr = addr_q[DW-1:1];
  assign w_idx    = widx_q;
  assign w_val    = wval_q;
  assign r_idx    = ridx_q;

  // R4
  busy_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (stat_q == ST_BUSY));

  // R5
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> ($past(en_q) > EN_MAX_OFF));

  // R6
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_nack) |=> (stat_q == ST_ERR && $stable(rdat_q)));

  // R8
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(op_hit && !eng_busy));

  // R3
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && kind_q && !eng_nack) |=> (rdat_q == $past(eng_rx) && stat_q == ST_ROK));
endmodule

// File: rtl/sccb_bridge.sv
module sccb_bridge
  import sccb_pkg::*;
#(
  parameter int QDIV = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  logic          go, go_rd;
  logic [6:0]    slv_addr;
  logic [DW-1:0] w_idx, w_val, r_idx;
  logic          busy, done, nack, tick;
  logic [DW-1:0] rx_byte;
  logic          scl_lvl, sda_lvl;

  sccb_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_busy  (busy),
    .eng_done  (done),
    .eng_nack  (nack),
    .eng_rx    (rx_byte),
    .go        (go),
    .go_rd     (go_rd),
    .slv_addr  (slv_addr),
    .w_idx     (w_idx),
    .w_val     (w_val),
    .r_idx     (r_idx)
  );

  sccb_qtick #(.QDIV(QDIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  sccb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .go       (go),
    .go_rd    (go_rd),
    .slv_addr (slv_addr),
    .w_idx    (w_idx),
    .w_val    (w_val),
    .r_idx    (r_idx),
    .sda_in   (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .busy     (busy),
    .done     (done),
    .nack     (nack),
    .rx_byte  (rx_byte)
  );

  assign scl_oe = ~scl_lvl;
  assign sda_oe = ~sda_lvl;
endmodule

// File: tb/sccb_bridge_bench.sv
module sccb_bridge_bench;
  localparam int QDIV = 4;
  localparam logic [6:0] DEV7 = 7'h30;
  localparam logic [9:0] EV_START = 10'h100;
  localparam logic [9:0] EV_STOP  = 10'h200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       scl_oe, sda_oe;
  logic       s_pull;
  logic       scl_line, sda_line;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_pull);

  sccb_bridge #(.QDIV(QDIV)) u_sccb_bridge (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_in    (sda_line)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int m_chk = 0, m_fail = 0;
  int wd_fail = 0;
  int cyc = 0;
  int drive_cnt = 0;
  int last_period = 0;
  logic [9:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // device model and monitor
  logic [7:0] mem [256];
  logic prev_scl, prev_sda, in_frame, got_rise, slave_tx, matched, rd_dir;
  logic [3:0] bitc;
  int byte_no;
  logic [7:0] sh, tx_sh, idx;
  int last_rise;
  logic [9:0] got_item;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      prev_scl = 1'b1; prev_sda = 1'b1; in_frame = 1'b0; got_rise = 1'b0;
      slave_tx = 1'b0; matched = 1'b0; rd_dir = 1'b0; bitc = 4'd0; byte_no = 0;
      sh = 8'd0; tx_sh = 8'd0; idx = 8'd0; s_pull = 1'b0; last_rise = 0;
    end else begin
      if (scl_oe || sda_oe) drive_cnt = drive_cnt + 1;
      got_item = 10'h3FF;
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        got_item = EV_START;
        in_frame = 1'b1; got_rise = 1'b0; bitc = 4'd0; byte_no = 0;
        slave_tx = 1'b0; s_pull = 1'b0;
      end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
        got_item = EV_STOP;
        in_frame = 1'b0; s_pull = 1'b0; slave_tx = 1'b0;
      end else if (in_frame && !prev_scl && scl_line) begin
        got_rise = 1'b1;
        if (byte_no == 0 && bitc == 4'd1) last_period = cyc - last_rise;
        last_rise = cyc;
        if (!slave_tx && bitc < 4'd8) sh = {sh[6:0], sda_line};
      end else if (in_frame && prev_scl && !scl_line && got_rise) begin
        if (bitc < 4'd7) begin
          bitc = bitc + 4'd1;
          if (slave_tx) begin
            tx_sh = {tx_sh[6:0], 1'b0};
            s_pull = ~tx_sh[7];
          end
        end else if (bitc == 4'd7) begin
          bitc = 4'd8;
          if (slave_tx) s_pull = 1'b0;
          else begin
            got_item = {2'b00, sh};
            if (byte_no == 0) begin
              matched = (sh[7:1] == DEV7);
              rd_dir = sh[0];
            end else if (byte_no == 1) begin
              idx = sh;
            end else if (matched) begin
              mem[idx] = sh;
              idx = idx + 8'd1;
            end
            s_pull = matched;
          end
        end else begin
          bitc = 4'd0;
          byte_no = byte_no + 1;
          s_pull = 1'b0;
          if (byte_no == 1 && rd_dir && matched) begin
            slave_tx = 1'b1;
            tx_sh = mem[idx];
            s_pull = ~tx_sh[7];
          end
        end
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
      if (got_item != 10'h3FF) begin
        m_chk = m_chk + 1;
        if (exp_q.size() == 0) begin
          m_fail = m_fail + 1;
          $display("FAIL R2 R3 R7 bus item: got %03h expected none", got_item);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          if (e != got_item) begin
            m_fail = m_fail + 1;
            $display("FAIL R2 R3 R7 bus item: got %03h expected %03h", got_item, e);
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h00;
    for (int k = 0; k < 2000; k++) begin
      brd(4'd1, st);
      if (st != 8'h00) break;
    end
  endtask

  task automatic push_write(input logic [7:0] a8, input logic [7:0] ix, input logic [7:0] v);
    exp_q.push_back(EV_START);
    exp_q.push_back({2'b00, a8});
    exp_q.push_back({2'b00, ix});
    exp_q.push_back({2'b00, v});
    exp_q.push_back(EV_STOP);
  endtask

  task automatic push_read(input logic [7:0] a8, input logic [7:0] ix);
    exp_q.push_back(EV_START);
    exp_q.push_back({2'b00, a8});
    exp_q.push_back({2'b00, ix});
    exp_q.push_back(EV_STOP);
    exp_q.push_back(EV_START);
    exp_q.push_back({2'b00, a8 | 8'h01});
    exp_q.push_back(EV_STOP);
  endtask

  task automatic push_nack(input logic [7:0] a8);
    exp_q.push_back(EV_START);
    exp_q.push_back({2'b00, a8});
    exp_q.push_back(EV_STOP);
  endtask

  initial begin
    #(8 * 150000);
    wd_fail = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + m_chk + 1, n_fail + m_fail + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int dc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    brd(4'd1, d); check("R1 status", d, 8'h00);
    brd(4'd2, d); check("R1 enable", d, 8'h00);
    brd(4'd3, d); check("R1 address", d, 8'h60);
    brd(4'd9, d); check("R1 rdata", d, 8'h00);
    check("R1 lines", {scl_oe, sda_oe}, 2'b00);

    // R5 gate closed at 0x00 and 0x01
    bwr(4'd4, 8'h12); bwr(4'd5, 8'hC3);
    dc = drive_cnt;
    bwr(4'd0, 8'h05);
    repeat (60) @(negedge clk);
    check("R5 no drive en=00", drive_cnt - dc, 0);
    bwr(4'd2, 8'h01);
    bwr(4'd0, 8'h70);
    repeat (60) @(negedge clk);
    check("R5 no drive en=01", drive_cnt - dc, 0);
    brd(4'd1, d); check("R5 status kept", d, 8'h00);

    bwr(4'd2, 8'h1E);

    // R2 write, R10 bit period
    push_write(8'h60, 8'h12, 8'hC3);
    bwr(4'd0, 8'h05);
    wait_done(d);
    check("R2 write status", d, 8'h04);
    check("R2 device memory", mem[8'h12], 8'hC3);
    check("R10 scl period", last_period, 4 * QDIV);

    // R4 and R8 busy status, opcode ignored while busy
    bwr(4'd4, 8'h20); bwr(4'd5, 8'h11);
    push_write(8'h60, 8'h20, 8'h11);
    bwr(4'd0, 8'h05);
    repeat (10) @(negedge clk);
    brd(4'd1, d); check("R4 status busy", d, 8'h00);
    bwr(4'd0, 8'h70);
    bwr(4'd0, 8'h05);
    wait_done(d);
    check("R8 status after ignored op", d, 8'h04);
    repeat (200) @(negedge clk);
    check("R8 no extra transaction", exp_q.size(), 0);

    // R3 reads
    bwr(4'd8, 8'h12);
    push_read(8'h60, 8'h12);
    bwr(4'd0, 8'h70);
    repeat (12) @(negedge clk);
    brd(4'd1, d); check("R4 status busy read", d, 8'h00);
    wait_done(d);
    check("R3 read status", d, 8'h01);
    brd(4'd9, d); check("R3 read data", d, 8'hC3);
    bwr(4'd8, 8'h07);
    push_read(8'h60, 8'h07);
    bwr(4'd0, 8'h70);
    wait_done(d);
    check("R3 read status 2", d, 8'h01);
    brd(4'd9, d); check("R3 read data 2", d, 8'h07 ^ 8'h5A);

    // R8 unknown opcode
    dc = drive_cnt;
    bwr(4'd0, 8'h33);
    repeat (60) @(negedge clk);
    check("R8 unknown op no drive", drive_cnt - dc, 0);
    brd(4'd1, d); check("R8 unknown op status", d, 8'h01);

    // R9 address bit 0 replaced by direction
    bwr(4'd3, 8'h61);
    bwr(4'd4, 8'h30); bwr(4'd5, 8'h9A);
    push_write(8'h60, 8'h30, 8'h9A);
    bwr(4'd0, 8'h05);
    wait_done(d);
    check("R9 write status", d, 8'h04);
    check("R9 device memory", mem[8'h30], 8'h9A);

    // R6 missing acknowledge
    bwr(4'd3, 8'h42);
    push_nack(8'h42);
    bwr(4'd0, 8'h05);
    wait_done(d);
    check("R6 write nack status", d, 8'h80);
    push_nack(8'h42);
    bwr(4'd0, 8'h70);
    wait_done(d);
    check("R6 read nack status", d, 8'h80);
    brd(4'd9, d); check("R6 rdata unchanged", d, 8'h07 ^ 8'h5A);
    check("R6 lines released", {scl_oe, sda_oe}, 2'b00);

    repeat (20) @(negedge clk);
    check("R7 all bus items seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk + m_chk, n_fail + m_fail + wd_fail);
    $finish;
  end
endmodule